// File: doc/BRIEF.md
# E1 Frame Alignment Receiver

The block watches a serial 2.048 Mbit/s E1 stream, one bit per clock, and finds where each 256-bit frame starts. A frame holds 32 eight-bit time slots, sent most significant bit first. Time slot 0 carries one of two words, and the two words alternate from frame to frame. The alignment word has the 7-bit code 0011011 in bits 6..0. The non-alignment word has a 1 in bit 6 and carries the spare bits.

While hunting, the receiver tests the last eight bits it has received. After each failed test it moves the candidate frame boundary by one bit. It declares alignment after three correct checks in a row: the alignment word, then bit 6 = 1 one frame later, then the alignment word again. Once aligned, it gives downstream logic a slot counter, a bit counter, a byte strobe and the parity of the current frame. It also latches the international bit and the national bits. Three errored alignment words in a row drop alignment, and the hunt restarts.

Top module: `e1_frame_align`

## Requirements
- R1: After reset `in_frame`=0, `fs_err`=1, `slot`=0, `bit_idx`=0, `byte_stb`=0, `intl_bit`=0 and `nat_bits`=0.
- R2: Alignment is declared after a time slot 0 byte with bits 6..0 = 0011011 (bit 7 first on the line), then a time slot 0 byte with bit 6 = 1 one frame later, then the 0011011 word again one frame after that. `in_frame` rises in the cycle after bit 0 of that third word arrives, with `slot`=1, `bit_idx`=0 and `nfas_frame`=0.
- R3: While aligned, `{slot,bit_idx}` gives the frame position (0..255) of the most recently received bit. `bit_idx`=0 is the first (most significant) bit of a slot. The count wraps from 255 to 0.
- R4: `byte_stb` is 1 exactly while `in_frame`=1 and `bit_idx`=7, which is the last bit of each slot.
- R5: `nfas_frame` is 0 during frames whose time slot 0 holds the alignment word and 1 during the frames between them. It toggles only at frame position 0.
- R6: While aligned, `intl_bit` takes bit 7 of time slot 0 of every frame. It updates when `slot`=1 and `bit_idx`=0.
- R7: `nat_bits` takes bits 4..0 of time slot 0 of non-alignment frames only, and updates at the same point as R6.
- R8: Alignment is lost on the third alignment word in a row that does not match. At that moment `slot`=0, `bit_idx`=7 and `nfas_frame`=0. One or two errored words, and any content of the non-alignment word, leave alignment in place.
- R9: `fs_err` is 1 whenever the receiver is not aligned, and stays 1 until alignment is declared again.
- R10: After the stream's frame boundary moves by any number of bits, the receiver hunts one bit at a time and aligns to the new boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial receive data |
| slot | output | 5 | Time slot of the last received bit |
| bit_idx | output | 3 | Bit position in the slot, 0 = MSB |
| byte_stb | output | 1 | Last bit of a slot received while aligned |
| in_frame | output | 1 | Frame alignment held |
| fs_err | output | 1 | Frame sync error, not aligned |
| nfas_frame | output | 1 | Current frame is a non-alignment frame |
| intl_bit | output | 1 | Latched international bit |
| nat_bits | output | 5 | Latched national bits |

## Verification
The counters and the byte strobe describe the bit shifted in at the same edge, so the bench checks them one step after each bit it drives. Alignment decisions are made on the bit at position 7 of time slot 0 and take effect at the next edge. For that reason lock, loss, `intl_bit` and `nat_bits` are checked after the bench has driven frame position 8 (slot 1, bit 0), and the loss case is checked once the third errored frame ends. Locking takes a variable number of frames, because the hunt slides one bit at a time and a chance match in the payload can cause a false lock. The bench therefore drives sixteen unchecked frames before it checks lock.

// File: rtl/e1_frame_align.sv
module e1_frame_align #(
  parameter int         LOSS_LIMIT = 3,
  parameter logic [6:0] FAS_WORD   = 7'b0011011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  output logic [4:0] slot,
  output logic [2:0] bit_idx,
  output logic       byte_stb,
  output logic       in_frame,
  output logic       fs_err,
  output logic       nfas_frame,
  output logic       intl_bit,
  output logic [4:0] nat_bits
);
  localparam int EW = $clog2(LOSS_LIMIT + 1);

  typedef enum logic [1:0] {HUNT, WAIT_NFAS, WAIT_FAS, LOCKED} st_t;

  st_t           st;
  logic [7:0]    sh, pos;
  logic          odd, fail;
  logic [EW-1:0] errs;

  wire ts0_end  = (pos == 8'd7);
  wire fas_hit  = (sh[6:0] == FAS_WORD);
  wire nfas_hit = sh[6];
  wire slip     = ts0_end && fail;

  always_comb begin
    case (st)
      HUNT:      fail = !fas_hit;
      WAIT_NFAS: fail = !nfas_hit;
      WAIT_FAS:  fail = !fas_hit;
      default:   fail = !odd && !fas_hit && (errs == EW'(LOSS_LIMIT - 1));
    endcase
  end

  assign slot       = pos[7:3];
  assign bit_idx    = pos[2:0];
  assign in_frame   = (st == LOCKED);
  assign fs_err     = !in_frame;
  assign byte_stb   = in_frame && (pos[2:0] == 3'd7);
  assign nfas_frame = odd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= HUNT;
      sh       <= '0;
      pos      <= '0;
      odd      <= 1'b0;
      errs     <= '0;
      intl_bit <= 1'b0;
      nat_bits <= '0;
    end else begin
      sh <= {sh[6:0], rx_bit};
      if (!slip) pos <= pos + 8'd1;
      if (pos == 8'd255) odd <= !odd;
      if (ts0_end) begin
        case (st)
          HUNT: if (fas_hit) begin
            st  <= WAIT_NFAS;
            odd <= 1'b0;
          end
          WAIT_NFAS: st <= nfas_hit ? WAIT_FAS : HUNT;
          WAIT_FAS: begin
            st   <= fas_hit ? LOCKED : HUNT;
            errs <= '0;
          end
          default: begin
            if (!odd) begin
              if (fas_hit)   errs <= '0;
              else if (fail) begin
                st   <= HUNT;
                errs <= '0;
              end else       errs <= errs + EW'(1);
            end else nat_bits <= sh[4:0];
            if (!fail) intl_bit <= sh[7];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/e1_frame_align_chk.sv
module e1_frame_align_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] slot,
  input logic [2:0] bit_idx,
  input logic       byte_stb,
  input logic       in_frame,
  input logic       nfas_frame,
  input logic       intl_bit,
  input logic [4:0] nat_bits
);
  wire [7:0] fpos = {slot, bit_idx};

  assert_lock_point_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> (slot == 5'd1 && bit_idx == 3'd0 && !nfas_frame));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame)) |-> (fpos == 8'($past(fpos) + 8'd1)));

  assert_stb_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(byte_stb) && in_frame) |-> (bit_idx == 3'd0));

  assert_parity_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame) && fpos == 8'd0) |-> (nfas_frame != $past(nfas_frame)));

  assert_parity_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && $past(in_frame) && fpos != 8'd0) |-> $stable(nfas_frame));

  assert_intl_when_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(intl_bit) |-> ($past(in_frame) && fpos == 8'd8));

  assert_nat_when_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nat_bits) |-> ($past(in_frame) && $past(nfas_frame) && fpos == 8'd8));

  assert_loss_point_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> (fpos == 8'd7 && !nfas_frame));
endmodule

bind e1_frame_align e1_frame_align_chk u_chk (.*);

// File: tb/tb_e1_frame_align.sv
module tb_e1_frame_align;
  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b0;
  logic [4:0] slot, nat_bits;
  logic [2:0] bit_idx;
  logic byte_stb, in_frame, fs_err, nfas_frame, intl_bit;

  int checks = 0, fails = 0;
  bit fodd = 1'b0;

  always #2 clk = !clk;

  e1_frame_align dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit b);
    rx_bit = b;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] ts0_word(bit odd_f, bit bad, bit i, logic [4:0] n);
    if (!odd_f) return {i, bad ? 7'b0011001 : 7'b0011011};
    return {i, !bad, 1'($urandom), n};
  endfunction

  task automatic send_frame(input bit bad, input bit chk);
    logic [7:0] byt;
    bit i = 1'($urandom);
    logic [4:0] n = 5'($urandom);
    bit ok = 1'b1;
    int act = 0, exp = 0;
    for (int s = 0; s < 32; s++) begin
      byt = (s == 0) ? ts0_word(fodd, bad, i, n) : 8'($urandom);
      for (int k = 7; k >= 0; k--) begin
        push(byt[k]);
        if (chk) begin
          if (ok && ({slot, bit_idx} != 8'(s * 8 + 7 - k) || !in_frame)) begin
            ok = 1'b0; act = {slot, bit_idx}; exp = s * 8 + 7 - k;
          end
          if (ok && (byte_stb != (k == 0) || nfas_frame != fodd)) begin
            ok = 1'b0; act = {byte_stb, nfas_frame}; exp = {k == 0, fodd};
          end
          if (s == 1 && k == 7) begin
            check(intl_bit == i, "R6 intl bit", intl_bit, i);
            if (fodd) check(nat_bits == n, "R7 national bits", nat_bits, n);
          end
        end
      end
    end
    if (chk) check(ok, "R3/R4/R5 counters, strobe, parity", act, exp);
    fodd = !fodd;
  endtask

  task automatic lock_and_check(input int slip_bits, input string req);
    for (int b = 0; b < slip_bits; b++) push(1'($urandom));
    for (int f = 0; f < 16; f++) send_frame(1'b0, 1'b0);
    check(in_frame && !fs_err, req, {in_frame, fs_err}, 2);
    for (int f = 0; f < 2; f++) send_frame(1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(!in_frame && fs_err && slot == 0 && bit_idx == 0 && !byte_stb, "R1 reset state",
          {in_frame, fs_err, slot, bit_idx, byte_stb}, 'h200);
    check(!intl_bit && nat_bits == 0, "R1 reset latches", {intl_bit, nat_bits}, 0);
    rst_n = 1'b1;
    lock_and_check(37, "R2 lock after alternation");
    for (int f = 0; f < 2; f++) send_frame(1'b0, 1'b1);
    // R8: non-alignment word errors ignored while aligned
    send_frame(1'b0, 1'b1);
    send_frame(1'b1, 1'b1);
    check(in_frame, "R8 bad non-alignment word ignored", in_frame, 1);
    // R8: two errored alignment words keep alignment, a good one clears the count
    for (int f = 0; f < 4; f++) send_frame(!fodd, 1'b1);
    check(in_frame, "R8 two errored words kept", in_frame, 1);
    send_frame(1'b0, 1'b1);
    send_frame(1'b0, 1'b1);
    for (int f = 0; f < 4; f++) send_frame(!fodd, 1'b1);
    send_frame(1'b1, 1'b0);
    check(!in_frame, "R8 loss on third errored word", in_frame, 0);
    check(fs_err, "R9 sync error after loss", fs_err, 1);
    send_frame(1'b0, 1'b0);
    check(fs_err, "R9 sync error held while hunting", fs_err, 1);
    lock_and_check(5, "R10 relock after 5-bit slip");
    for (int r = 0; r < 4; r++) lock_and_check(1 + ($urandom % 255), "R10 relock after random slip");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule